// File: doc/BRIEF.md
# Oversampling Serial Bus Slave

This block is the receiving end of a four-wire serial link. The link's bit clock, data input and active-low select reach the block as plain asynchronous signals. None of them ever clocks a flop. The block samples all three with its own system clock, which runs six times faster than the bit clock. It synchronises them and turns changes of the synchronised bit clock into one-cycle edge events. The master launches data when the bit clock rises and samples it when the bit clock falls. The block follows the same rule: it takes a receive bit at each detected falling edge and moves its output bit at each detected rising edge.

The surrounding logic presents a parallel word for the block to send and collects a parallel word that the block has received. The send word is captured when the select goes active, and again at every word boundary inside one select. Its most significant bit is put on the output pin before the first clock edge arrives. Each complete received word is presented together with a one-cycle strobe. Several words may be transferred back to back while the select stays low.

A small state machine sequences each transfer. **ST_IDLE** (select inactive, output low) goes to **ST_ARMED** on the transition *select_seen*, which also loads the send word. ST_ARMED holds the pre-driven first bit. It goes to **ST_SHIFT** on the transition *first_edge*, which is any detected bit-clock edge. In ST_ARMED a rising edge does not move the output. Every state returns to ST_IDLE on the transition *deselect* when the synchronised select goes high.

Top module: `ovs_spi_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `miso_out` is 0, `rx_valid` is 0 and `rx_word` is 0.
- R2: Received bits are taken from `mosi_in` at detected falling edges of `sclk_in`, most significant bit first. The 16th bit sampled in a word is bit 0 of `rx_word`.
- R3: `rx_valid` is high for exactly one system clock per completed word, 3 system clocks after the 16th falling edge of `sclk_in`. `rx_word` holds that word from the same cycle.
- R4: While the synchronised `csn_in` is high, `miso_out` is 0. Toggling `sclk_in` and `mosi_in` in that time produces no `rx_valid`.
- R5: No more than 3 system clocks after `csn_in` falls, `miso_out` shows bit 15 of `tx_word`.
- R6: The first rising edge of `sclk_in` after select leaves `miso_out` unchanged. Each later rising edge puts the next lower bit of the send word on `miso_out`, no more than 3 system clocks after the pin edge.
- R7: `miso_out` changes only in the cycle after a detected rising edge, after a load from ST_IDLE, or after the select deasserts.
- R8: Inside one select, the 16th falling edge captures `tx_word` again. The next rising edge drives bit 15 of that new word, and the receive bit count restarts at 0.
- R9: Deasserting `csn_in` in the middle of a word discards the partial word with no `rx_valid`. The next select starts counting from bit 0.
- R10: A change of `tx_word` between its capture points has no effect on the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, six times the bit clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Bit clock from the master, asynchronous |
| mosi_in | input | 1 | Serial data from the master, asynchronous |
| csn_in | input | 1 | Active-low select from the master, asynchronous |
| tx_word | input | WORD_W | Parallel word to send |
| miso_out | output | 1 | Serial data to the master |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |

## Verification
The hardest case to reach is the word boundary inside a long select. There, the falling edge that completes the receive word must also recapture the send word. The next rising edge must then launch that word's top bit rather than a stale shifted zero. The bench reaches it by holding the select across several consecutive words. It changes `tx_word` halfway through each word, so one sweep shows that the mid-word change is ignored and that the boundary reload picks up the new value. A select dropped after seven bits, followed by a fresh transfer, covers the discard-and-restart path.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    // Transfer sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } ovs_state_e;

endpackage

// File: rtl/ovs_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
module ovs_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ovs_edge.sv
// Turns level changes of a synchronised signal into one-cycle events.
module ovs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/ovs_tx_shift.sv
// Send path: parallel load, boundary reload and MSB-first serial shift.
module ovs_tx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic              reload_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);

    logic [WORD_W-1:0] sh_q;
    logic              bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (clear_i) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (load_i) begin
            // top bit goes straight to the pin, the rest waits
            bit_q <= word_i[WORD_W-1];
            sh_q  <= {word_i[WORD_W-2:0], 1'b0};
        end else if (reload_i) begin
            // word boundary: next rising edge launches the full new word
            sh_q  <= word_i;
        end else if (shift_i) begin
            bit_q <= sh_q[WORD_W-1];
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/ovs_rx_shift.sv
// Receive path: bit counter, serial-to-parallel shift and word strobe.
module ovs_rx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              bit_i,
    output logic              word_end_o,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              last_bit;

    assign last_bit   = (cnt_q == LAST_IDX);
    assign word_end_o = sample_i & last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear_i) begin
                cnt_q <= '0;
                sh_q  <= '0;
            end else if (sample_i) begin
                sh_q <= {sh_q[WORD_W-3:0], bit_i};
                if (last_bit) begin
                    cnt_q   <= '0;
                    word_q  <= {sh_q, bit_i};
                    valid_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/ovs_spi_slave.sv
// Serial bus slave that oversamples its bit clock with the system clock.
module ovs_spi_slave
    import ovs_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              csn_in,
    input  logic [WORD_W-1:0] tx_word,
    output logic              miso_out,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    localparam int PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_RST = 3'b100; // select idles inactive

    logic [PIN_W-1:0] pins_s;
    logic             sclk_s;
    logic             mosi_s;
    logic             csn_s;
    logic             rise_evt;
    logic             fall_evt;
    logic             word_end;

    ovs_state_e state_q;
    ovs_state_e state_d;

    logic tx_clear, tx_load, tx_reload, tx_shift;
    logic rx_clear, rx_sample;

    // all three pins share one synchroniser depth, keeping data aligned to clock
    ovs_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({csn_in, mosi_in, sclk_in}),
        .q_sync  (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign csn_s  = pins_s[2];

    ovs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sclk_s),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!csn_s) state_d = ST_ARMED;                 // select_seen
            end
            ST_ARMED: begin
                if (csn_s)                      state_d = ST_IDLE;  // deselect
                else if (rise_evt || fall_evt)  state_d = ST_SHIFT; // first_edge
            end
            ST_SHIFT: begin
                if (csn_s) state_d = ST_IDLE;                   // deselect
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        tx_clear  = 1'b0;
        tx_load   = 1'b0;
        tx_reload = 1'b0;
        tx_shift  = 1'b0;
        rx_clear  = 1'b0;
        rx_sample = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tx_clear = csn_s;
                rx_clear = 1'b1;
                tx_load  = !csn_s;
            end
            ST_ARMED: begin
                tx_clear  = csn_s;
                rx_clear  = csn_s;
                rx_sample = !csn_s && fall_evt;
                tx_reload = word_end;
            end
            ST_SHIFT: begin
                tx_clear  = csn_s;
                rx_clear  = csn_s;
                rx_sample = !csn_s && fall_evt;
                tx_reload = word_end;
                tx_shift  = !csn_s && rise_evt;
            end
            default: begin
                tx_clear = 1'b1;
                rx_clear = 1'b1;
            end
        endcase
    end

    ovs_tx_shift #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tx_clear),
        .load_i   (tx_load),
        .reload_i (tx_reload),
        .shift_i  (tx_shift),
        .word_i   (tx_word),
        .bit_o    (miso_out)
    );

    ovs_rx_shift #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (rx_clear),
        .sample_i   (rx_sample),
        .bit_i      (mosi_s),
        .word_end_o (word_end),
        .word_o     (rx_word),
        .valid_o    (rx_valid)
    );

endmodule

// File: rtl/ovs_spi_slave_chk.sv
// Protocol checker attached to the slave.
module ovs_spi_slave_chk
    import ovs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       miso_out,
    input logic       rx_valid,
    input ovs_state_e state_q,
    input logic       csn_s,
    input logic       rise_evt,
    input logic       fall_evt
);

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fall_evt)); // R3

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R3

    AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (miso_out == 1'b0)); // R4

    AST_MISO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_out) |-> ($past(rise_evt) || ($past(state_q) == ST_IDLE) || $past(csn_s))); // R7

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (state_q == ST_IDLE)); // R9

endmodule

bind ovs_spi_slave ovs_spi_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso_out (miso_out),
    .rx_valid (rx_valid),
    .state_q  (state_q),
    .csn_s    (csn_s),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
);

// File: tb/ovs_spi_slave_tb_top.sv
module ovs_spi_slave_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_in = 1'b0;
    logic         mosi_in = 1'b0;
    logic         csn_in = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic         miso_out;
    logic [W-1:0] rx_word;
    logic         rx_valid;

    int checks = 0;
    int failures = 0;
    int vcnt = 0;
    int run_err = 0;
    logic prev_valid = 1'b0;
    logic [W-1:0] rx_log [128];

    always #2 clk = ~clk;

    ovs_spi_slave #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_in),
        .mosi_in  (mosi_in),
        .csn_in   (csn_in),
        .tx_word  (tx_word),
        .miso_out (miso_out),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    // word log and strobe width monitor (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (vcnt < 128) rx_log[vcnt] = rx_word;
                vcnt = vcnt + 1;
                if (prev_valid) run_err = run_err + 1;
            end
            prev_valid = rx_valid;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] tx_val(input int i);
        if (i == 0) return 16'h0000;
        if (i == 1) return 16'hFFFF;
        return 16'(i * 40503 + 7) ^ 16'(i << 5);
    endfunction

    function automatic logic [W-1:0] mo_val(input int i);
        if (i == 0) return 16'hFFFF;
        if (i == 1) return 16'h0000;
        return 16'(i * 21845) ^ 16'h5AA5 ^ 16'(i);
    endfunction

    // One select with nw back-to-back words; tx_word moves mid-word (R10, R8)
    task automatic run_frame(input int nw, input int base);
        int v0;
        logic [W-1:0] got;
        logic [W-1:0] cur;
        v0 = vcnt;
        tx_word = tx_val(base);
        csn_in = 1'b0;
        tick(3);
        chk(miso_out == tx_val(base)[W-1], "R5 msb after select", 32'(miso_out), 32'(tx_val(base)[W-1]));
        tick(3);
        for (int w = 0; w < nw; w++) begin
            got = '0;
            cur = mo_val(base + w);
            for (int b = 0; b < W; b++) begin
                sclk_in = 1'b1;
                mosi_in = cur[W-1-b];
                if (b == 8) tx_word = tx_val(base + w + 1);
                tick(3);
                got[W-1-b] = miso_out;
                sclk_in = 1'b0;
                tick(3);
            end
            if (w == 0)
                chk(got == tx_val(base), "R6 R10 first word sent", 32'(got), 32'(tx_val(base)));
            else
                chk(got == tx_val(base + w), "R8 next word sent", 32'(got), 32'(tx_val(base + w)));
        end
        tick(2);
        csn_in = 1'b1;
        tick(3);
        chk(miso_out == 1'b0, "R4 miso low after deselect", 32'(miso_out), 32'h0);
        tick(3);
        chk(vcnt - v0 == nw, "R3 strobe count", 32'(vcnt - v0), 32'(nw));
        for (int w = 0; w < nw; w++)
            chk(rx_log[v0 + w] == mo_val(base + w), "R2 received word", 32'(rx_log[v0 + w]), 32'(mo_val(base + w)));
    endtask

    initial begin
        int v0;
        rst_n = 1'b0;
        tick(3);
        chk(miso_out == 1'b0 && rx_valid == 1'b0 && rx_word == '0, "R1 reset outputs",
            {15'h0, miso_out, rx_word[W-1:0]} | 32'(rx_valid), 32'h0);
        rst_n = 1'b1;
        tick(1);
        chk(miso_out == 1'b0 && rx_valid == 1'b0 && rx_word == '0, "R1 first cycle after reset",
            32'(rx_word), 32'h0);
        tick(4);

        run_frame(1, 0);
        run_frame(3, 2);

        // R9: drop the select after 7 bits
        v0 = vcnt;
        tx_word = 16'hA5C3;
        csn_in = 1'b0;
        tick(6);
        for (int b = 0; b < 7; b++) begin
            sclk_in = 1'b1; mosi_in = b[0]; tick(3);
            sclk_in = 1'b0; tick(3);
        end
        csn_in = 1'b1;
        tick(6);
        chk(vcnt == v0, "R9 partial word discarded", 32'(vcnt), 32'(v0));
        chk(miso_out == 1'b0, "R9 R4 miso low after abort", 32'(miso_out), 32'h0);
        run_frame(2, 10);

        // R4: activity while deselected is ignored
        v0 = vcnt;
        for (int b = 0; b < 20; b++) begin
            sclk_in = 1'b1; mosi_in = ~b[0]; tick(3);
            chk(miso_out == 1'b0, "R4 miso low while deselected", 32'(miso_out), 32'h0);
            sclk_in = 1'b0; tick(3);
        end
        chk(vcnt == v0, "R4 no strobe while deselected", 32'(vcnt), 32'(v0));

        // sweep of frame lengths and data patterns
        for (int f = 0; f < 8; f++) run_frame(f % 4 + 1, 20 + f * 5);

        chk(run_err == 0, "R3 strobe one cycle wide", 32'(run_err), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule